// File: doc/BRIEF.md
# SD Command Line Sequencer

This block is the host end of the command wire of an SD-style card bus. It takes a request (index, argument, whether a reply is expected and whether that reply is long). It turns the request into a 48-bit frame with its own CRC7 and shifts it out one bit per clock. It then lets go of the wire for the turnaround period and listens for the card's start bit. When the start bit arrives, it captures the reply and checks it.

The sequencer starts in an identification mode. In this mode the wire is open-drain: the host only ever pulls it low. The host also waits longer before it will accept a start bit, and it does not check the reply CRC. When the reply to the address-assignment command (index 3) arrives, the wire switches to push-pull for good.

Between transactions the block holds a minimum number of idle bit periods. One spacing applies after a reply. Another applies after a command that had no reply, or whose reply never came. Request acceptance is held off until that spacing has elapsed.

Top module: `sd_cmd_sequencer`

## Requirements
- R1: After reset the wire is released (cmd_oe 0, cmd_out 1), push_pull is 0, req_ready is 1 and rsp_valid is 0.
- R2: An accepted request (req_valid while req_ready) is sent starting the next cycle as 48 bits, most significant first: 0, 1, req_index[5:0], req_arg[31:0], CRC7, 1. The CRC7 uses polynomial x^7+x^3+1 with a zero start value and is taken over the first 40 bits. req_ready stays low from the accepting edge until the block is idle again.
- R3: In identification mode (push_pull 0), a 0 bit is driven (cmd_oe 1, cmd_out 0), while 1 bits and idle cycles release the wire (cmd_oe 0, cmd_out 1). In push-pull mode cmd_oe is 1 and cmd_out carries the bit in every send and idle cycle, with idle driven as 1.
- R4: While a reply is awaited or received, the wire is released in every cycle after the end bit. A low level on cmd_in in the two turnaround cycles right after the end bit is not taken as a start bit.
- R5: In identification mode a low level before cycle 6 after the end bit is ignored, and a start bit in cycle 6 is accepted. Cycle n is the n-th cycle after the end bit.
- R6: A reply is captured as 136 bits when req_long was set, otherwise as 48 bits. It is right-aligned in rsp_frame with the start bit at the top position of its length and zeros above. rsp_valid is high for exactly the one cycle after the reply's end bit.
- R7: rsp_crc_err is 1 only for a 48-bit reply in push-pull mode whose bits [7:1] differ from the CRC7 of its bits [47:8]. Long replies and identification-mode replies report 0.
- R8: A start bit in cycle 64 after the end bit is still accepted. If none has come by then, rsp_valid rises in cycle 65 with rsp_timeout 1, rsp_frame all zero and rsp_crc_err 0.
- R9: A completed reply to index 3 in identification mode sets push_pull from the cycle after the reply's end bit, and push_pull stays set until reset. A timeout does not set it.
- R10: After a reply's end bit, the next start bit comes no sooner than 8 idle cycles later, and exactly 8 later when a request is already waiting.
- R11: After the end bit of a command with no reply, or after the last listening cycle of a timeout, the next start bit comes no sooner than 8 idle cycles later, and exactly 8 later when a request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one wire bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp | input | 1 | A reply is expected |
| req_long | input | 1 | The expected reply is 136 bits |
| cmd_out | output | 1 | Value for the command wire |
| cmd_oe | output | 1 | Drive enable for the command wire |
| cmd_in | input | 1 | Sampled level of the command wire |
| push_pull | output | 1 | 1 once the wire is in push-pull mode |
| rsp_valid | output | 1 | One-cycle pulse: reply result ready |
| rsp_timeout | output | 1 | Result was a timeout |
| rsp_crc_err | output | 1 | Reply CRC7 mismatch |
| rsp_frame | output | 136 | Captured reply, right-aligned |

## Verification
Every result has a fixed due cycle. The start bit appears one cycle after the accepting edge. The reply result appears one cycle after the last reply bit. A timeout result appears in cycle 65 after the command end bit. The next start bit appears exactly 8 idle cycles after a reply end bit, a reply-less end bit or the last listening cycle. The bench's behavioural model steps through these cycles one at a time and sets the expected wire value, ready, mode and result pulse for each cycle. It compares all of them on the falling edge of every clock. The card's bits are applied on the falling edge so that they are sampled on the next rising edge, which is the cycle the model assumes.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_RSP,
    ST_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    RX_OFF,
    RX_WAIT,
    RX_RECV
  } rx_phase_e;

  localparam int CRC_W = 7;

endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 #(
  parameter int W = 40
) (
  input  logic [W-1:0] data,
  output logic [6:0]   crc
);

  // Serial CRC7 (x^7 + x^3 + 1), zero start, message fed MSB first.
  always_comb begin
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = W - 1; i >= 0; i--) begin
      fb = data[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    crc = c;
  end

endmodule

// File: rtl/sd_cmd_shifter.sv
module sd_cmd_shifter #(
  parameter int LEN = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [LEN-1:0] frame_in,
  output logic           bit_out,
  output logic           last
);

  localparam int CW = $clog2(LEN);

  logic [LEN-1:0] sh_q, sh_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = frame_in;
      cnt_d = CW'(LEN - 1);
    end else if (shift) begin
      sh_d = {sh_q[LEN-2:0], 1'b0};
      if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_out = sh_q[LEN-1];
  assign last    = (cnt_q == '0);

  // R2: a new frame is only loaded once the previous one has fully left
  a_r2_no_reload_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> last);

endmodule

// File: rtl/sd_gap_timer.sv
module sd_gap_timer #(
  parameter int MAXV = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [$clog2(MAXV+1)-1:0]  load_val,
  output logic                       zero
);

  localparam int GW = $clog2(MAXV + 1);

  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R10 / R11: spacing loads never exceed the configured maximum
  a_r10_load_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val <= GW'(MAXV)));

  // R11: a running count reaches zero one step at a time
  a_r11_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && !load) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/sd_rsp_capture.sv
module sd_rsp_capture
  import sd_cmd_pkg::*;
#(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int N_ID      = 5,
  parameter int TURN      = 2,
  parameter int TMO       = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                id_mode,
  input  logic                long_rsp,
  input  logic                line_in,
  output logic                finish,
  output logic                finish_tmo,
  output logic                rsp_valid,
  output logic                rsp_timeout,
  output logic                rsp_crc_err,
  output logic [LONG_LEN-1:0] rsp_frame
);

  localparam int KW = $clog2(TMO + 1);
  localparam int RW = $clog2(LONG_LEN);

  rx_phase_e           phase_q, phase_d;
  logic [KW-1:0]       k_q, k_d;
  logic [RW-1:0]       rcnt_q, rcnt_d;
  logic [LONG_LEN-2:0] sh_q, sh_d;
  logic                long_q, long_d;
  logic                id_q, id_d;
  logic                valid_d, tmo_d, crc_d;
  logic [LONG_LEN-1:0] frame_d;

  logic [KW-1:0]       lo;
  logic                start_ok;
  logic [LONG_LEN-1:0] nf;
  logic [CRC_W-1:0]    crc_calc;
  logic                crc_mis;

  assign lo         = id_q ? KW'(N_ID) : KW'(TURN);
  assign start_ok   = (phase_q == RX_WAIT) && (k_q > lo) && !line_in;
  assign finish_tmo = (phase_q == RX_WAIT) && !start_ok && (k_q == KW'(TMO));
  assign finish     = finish_tmo || ((phase_q == RX_RECV) && (rcnt_q == '0));
  assign nf         = {sh_q, line_in};

  sd_crc7 #(.W(SHORT_LEN - 8)) u_chk (
    .data (nf[SHORT_LEN-1:8]),
    .crc  (crc_calc)
  );

  assign crc_mis = (crc_calc != nf[7:1]);

  always_comb begin
    phase_d = phase_q;
    k_d     = k_q;
    rcnt_d  = rcnt_q;
    sh_d    = sh_q;
    long_d  = long_q;
    id_d    = id_q;
    valid_d = 1'b0;
    tmo_d   = rsp_timeout;
    crc_d   = rsp_crc_err;
    frame_d = rsp_frame;
    unique case (phase_q)
      RX_OFF: begin
        if (arm) begin
          phase_d = RX_WAIT;
          k_d     = KW'(1);
          long_d  = long_rsp;
          id_d    = id_mode;
        end
      end
      RX_WAIT: begin
        if (start_ok) begin
          phase_d = RX_RECV;
          rcnt_d  = long_q ? RW'(LONG_LEN - 2) : RW'(SHORT_LEN - 2);
          sh_d    = '0;
        end else if (finish_tmo) begin
          phase_d = RX_OFF;
          valid_d = 1'b1;
          tmo_d   = 1'b1;
          crc_d   = 1'b0;
          frame_d = '0;
        end else begin
          k_d = k_q + KW'(1);
        end
      end
      RX_RECV: begin
        sh_d = nf[LONG_LEN-2:0];
        if (rcnt_q == '0) begin
          phase_d = RX_OFF;
          valid_d = 1'b1;
          tmo_d   = 1'b0;
          frame_d = nf;
          crc_d   = !id_q && !long_q && crc_mis;
        end else begin
          rcnt_d = rcnt_q - RW'(1);
        end
      end
      default: phase_d = RX_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= RX_OFF;
      k_q         <= '0;
      rcnt_q      <= '0;
      sh_q        <= '0;
      long_q      <= 1'b0;
      id_q        <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_crc_err <= 1'b0;
      rsp_frame   <= '0;
    end else begin
      phase_q     <= phase_d;
      k_q         <= k_d;
      rcnt_q      <= rcnt_d;
      sh_q        <= sh_d;
      long_q      <= long_d;
      id_q        <= id_d;
      rsp_valid   <= valid_d;
      rsp_timeout <= tmo_d;
      rsp_crc_err <= crc_d;
      rsp_frame   <= frame_d;
    end
  end

  // R6: the result strobe lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: a timeout result carries no frame and no CRC error
  a_r8_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_timeout) |-> (!rsp_crc_err && (rsp_frame == '0)));

  // R7: long replies never report a CRC error
  a_r7_long_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !finish_tmo && long_q) |=> !rsp_crc_err);

  // R4: the receiver is never armed while it is already busy
  a_r4_arm_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (phase_q == RX_OFF));

endmodule

// File: rtl/sd_cmd_sequencer.sv
module sd_cmd_sequencer
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int N_ID      = 5,
  parameter int N_RC      = 8,
  parameter int N_CC      = 8,
  parameter int TURN      = 2,
  parameter int TMO       = 64,
  parameter int ADDR_IDX  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [IDX_W-1:0]    req_index,
  input  logic [ARG_W-1:0]    req_arg,
  input  logic                req_rsp,
  input  logic                req_long,
  output logic                cmd_out,
  output logic                cmd_oe,
  input  logic                cmd_in,
  output logic                push_pull,
  output logic                rsp_valid,
  output logic                rsp_timeout,
  output logic                rsp_crc_err,
  output logic [LONG_LEN-1:0] rsp_frame
);

  localparam int CMD_LEN  = IDX_W + ARG_W + CRC_W + 3;
  localparam int CRC_SPAN = CMD_LEN - CRC_W - 1;
  localparam int GAP_MAX  = (N_RC > N_CC) ? N_RC : N_CC;
  localparam int GW       = $clog2(GAP_MAX + 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rsp_q, rsp_d;
  logic             long_q, long_d;
  logic             pp_q, pp_d;

  logic               accept;
  logic [CRC_W-1:0]   cmd_crc;
  logic [CMD_LEN-1:0] frame;
  logic               ser_bit, ser_last, ser_shift;
  logic               arm;
  logic               gap_load, gap_zero;
  logic [GW-1:0]      gap_val;
  logic               rx_finish, rx_tmo;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign req_ready = (state_q == ST_IDLE);
  assign push_pull = pp_q;

  sd_crc7 #(.W(CRC_SPAN)) u_cmd_crc (
    .data ({2'b01, req_index, req_arg}),
    .crc  (cmd_crc)
  );

  assign frame = {2'b01, req_index, req_arg, cmd_crc, 1'b1};

  assign ser_shift = (state_q == ST_SEND);

  sd_cmd_shifter #(.LEN(CMD_LEN)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .shift    (ser_shift),
    .frame_in (frame),
    .bit_out  (ser_bit),
    .last     (ser_last)
  );

  assign arm = (state_q == ST_SEND) && ser_last && rsp_q;

  sd_rsp_capture #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .N_ID      (N_ID),
    .TURN      (TURN),
    .TMO       (TMO)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .id_mode     (!pp_q),
    .long_rsp    (long_q),
    .line_in     (cmd_in),
    .finish      (rx_finish),
    .finish_tmo  (rx_tmo),
    .rsp_valid   (rsp_valid),
    .rsp_timeout (rsp_timeout),
    .rsp_crc_err (rsp_crc_err),
    .rsp_frame   (rsp_frame)
  );

  sd_gap_timer #(.MAXV(GAP_MAX)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    rsp_d    = rsp_q;
    long_d   = long_q;
    pp_d     = pp_q;
    gap_load = 1'b0;
    gap_val  = GW'(N_CC - 2);
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_SEND;
          idx_d   = req_index;
          rsp_d   = req_rsp;
          long_d  = req_long;
        end
      end
      ST_SEND: begin
        if (ser_last) begin
          if (rsp_q) begin
            state_d = ST_RSP;
          end else begin
            state_d  = ST_GAP;
            gap_load = 1'b1;
            gap_val  = GW'(N_CC - 2);
          end
        end
      end
      ST_RSP: begin
        if (rx_finish) begin
          state_d  = ST_GAP;
          gap_load = 1'b1;
          gap_val  = rx_tmo ? GW'(N_CC - 2) : GW'(N_RC - 2);
          if (!rx_tmo && !pp_q && (idx_q == IDX_W'(ADDR_IDX))) pp_d = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Line drive
  always_comb begin
    unique case (state_q)
      ST_SEND: begin
        cmd_out = ser_bit;
        cmd_oe  = pp_q | ~ser_bit;
      end
      ST_RSP: begin
        cmd_out = 1'b1;
        cmd_oe  = 1'b0;
      end
      default: begin
        cmd_out = 1'b1;
        cmd_oe  = pp_q;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rsp_q   <= 1'b0;
      long_q  <= 1'b0;
      pp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rsp_q   <= rsp_d;
      long_q  <= long_d;
      pp_q    <= pp_d;
    end
  end

  // R3: in open-drain mode the host only ever pulls low
  a_r3_open_drain_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_pull && cmd_oe) |-> !cmd_out);

  // R4: the host keeps off the wire while the card may answer
  a_r4_released_while_listening: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RSP) |-> (!cmd_oe && cmd_out));

  // R2: after accepting, the block is busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: push-pull mode never reverts without reset
  a_r9_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull |=> push_pull);

  // R10: no return to idle while spacing is still running
  a_r10_gap_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && !gap_zero) |=> !req_ready);

endmodule

// File: tb/sd_cmd_sequencer_test.sv
module sd_cmd_sequencer_test;

  localparam int NRC = 8;
  localparam int NCC = 8;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         req_rsp;
  logic         req_long;
  logic         cmd_out;
  logic         cmd_oe;
  logic         cmd_in;
  logic         push_pull;
  logic         rsp_valid;
  logic         rsp_timeout;
  logic         rsp_crc_err;
  logic [135:0] rsp_frame;

  int total = 0;
  int bad   = 0;
  bit pp_m  = 1'b0;
  bit ended = 1'b0;

  sd_cmd_sequencer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_index   (req_index),
    .req_arg     (req_arg),
    .req_rsp     (req_rsp),
    .req_long    (req_long),
    .cmd_out     (cmd_out),
    .cmd_oe      (cmd_oe),
    .cmd_in      (cmd_in),
    .push_pull   (push_pull),
    .rsp_valid   (rsp_valid),
    .rsp_timeout (rsp_timeout),
    .rsp_crc_err (rsp_crc_err),
    .rsp_frame   (rsp_frame)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference CRC7 as polynomial long division of (message * x^7) by 0x89
  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--) begin
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] c, input bit corrupt);
    logic [6:0] k;
    k = ref_crc({2'b00, idx, c});
    if (corrupt) k = k ^ 7'h01;
    return {88'b0, 2'b00, idx, c, k, 1'b1};
  endfunction

  task automatic check_val(input string tag, input string what, input logic [135:0] act, input logic [135:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bit period: compare on the falling edge, then drive the card's bit for this cycle
  task automatic tick(input logic e_oe, input logic e_out, input logic e_rdy, input logic e_rv,
                      input string tag, input logic in_bit);
    @(negedge clk);
    check_val(tag, "cmd_oe", cmd_oe, e_oe);
    check_val(tag, "cmd_out", cmd_out, e_out);
    check_val(tag, "req_ready", req_ready, e_rdy);
    check_val("R6", "rsp_valid", rsp_valid, e_rv);
    check_val("R9", "push_pull", push_pull, pp_m);
    cmd_in = in_bit;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_index = '0;
    req_arg   = '0;
    req_rsp   = 1'b0;
    req_long  = 1'b0;
    cmd_in    = 1'b1;
    pp_m      = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, one cycle after release
    tick(1'b0, 1'b1, 1'b1, 1'b0, "R1", 1'b1);
  endtask

  // start_k = 0 means the card never answers; glitch_k is a cycle with a stray low level
  task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit rsp, input bit lng,
                        input int start_k, input int glitch_k, input logic [135:0] card, input bit exp_crc);
    logic [47:0]  f;
    logic [135:0] expf;
    int           len;
    int           last_k;
    int           n;
    bit           b;
    string        gtag;
    // accept cycle
    tick(pp_m, 1'b1, 1'b1, 1'b0, "R2", 1'b1);
    req_valid = 1'b1;
    req_index = idx;
    req_arg   = arg;
    req_rsp   = rsp;
    req_long  = lng;
    f = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    for (int i = 47; i >= 0; i--) begin
      tick(pp_m ? 1'b1 : ~f[i], f[i], 1'b0, 1'b0, pp_m ? "R2_R3" : "R3_R2", 1'b1);
      req_valid = 1'b0;
    end
    if (rsp) begin
      len    = lng ? 136 : 48;
      last_k = (start_k == 0) ? 64 : start_k + len - 1;
      for (int k = 1; k <= last_k; k++) begin
        if (start_k == 0)      b = 1'b1;
        else if (k < start_k)  b = (k == glitch_k) ? 1'b0 : 1'b1;
        else                   b = card[len - 1 - (k - start_k)];
        tick(1'b0, 1'b1, 1'b0, 1'b0, pp_m ? "R4" : "R5", b);
      end
      if (start_k != 0 && idx == 6'd3 && !pp_m) pp_m = 1'b1;
      expf = (start_k == 0) ? '0 : (lng ? card : {88'b0, card[47:0]});
      n    = (start_k == 0) ? NCC : NRC;
      gtag = (start_k == 0) ? "R11" : "R10";
    end else begin
      expf = '0;
      n    = NCC;
      gtag = "R11";
    end
    for (int t = 1; t <= n - 1; t++) begin
      tick(pp_m, 1'b1, 1'b0, (rsp && t == 1), gtag, 1'b1);
      if (rsp && t == 1) begin
        check_val("R6", "rsp_frame", rsp_frame, expf);
        check_val("R8", "rsp_timeout", rsp_timeout, (start_k == 0));
        check_val("R7", "rsp_crc_err", rsp_crc_err, exp_crc);
      end
    end
  endtask

  initial begin
    do_reset();
    // identification mode: reply-less reset command, then spacing R11
    do_cmd(6'd0, 32'h0, 1'b0, 1'b0, 0, 0, '0, 1'b0);
    // identification mode long reply, stray low in cycle 5, start in cycle 6 (R5), CRC unchecked (R7)
    do_cmd(6'd2, 32'h0, 1'b1, 1'b1, 6, 5,
           {2'b00, {4{32'hA5C3_1E77}}, 5'h0B, 1'b1}, 1'b0);
    // address assignment with corrupted CRC: not flagged in identification mode, mode switches (R9)
    do_cmd(6'd3, 32'h0, 1'b1, 1'b0, 7, 0, mk_short(6'd3, 32'hBEEF_0500, 1'b1), 1'b0);
    // push-pull short reply, stray low during turnaround ignored (R4), earliest start cycle 3
    do_cmd(6'd7, 32'h1234_0000, 1'b1, 1'b0, 3, 2, mk_short(6'd7, 32'h0000_0700, 1'b0), 1'b0);
    // push-pull short reply with corrupted CRC (R7)
    do_cmd(6'd13, 32'h1234_0000, 1'b1, 1'b0, 10, 0, mk_short(6'd13, 32'h0000_0900, 1'b1), 1'b1);
    // long reply starting at the last allowed cycle 64 (R8)
    do_cmd(6'd9, 32'h5555_AAAA, 1'b1, 1'b1, 64, 0,
           {2'b00, {4{32'h0F1E_2D3C}}, 5'h15, 1'b1}, 1'b0);
    // no answer: timeout (R8), then spacing R11
    do_cmd(6'd55, 32'h0, 1'b1, 1'b0, 0, 0, '0, 1'b0);
    // two reply-less commands back to back (R11)
    do_cmd(6'd12, 32'hFFFF_FFFF, 1'b0, 1'b0, 0, 0, '0, 1'b0);
    do_cmd(6'd16, 32'h0000_0200, 1'b0, 1'b0, 0, 0, '0, 1'b0);
    // fresh reset: timeout on address assignment keeps open-drain mode (R9)
    do_reset();
    do_cmd(6'd3, 32'h0, 1'b1, 1'b0, 0, 0, '0, 1'b0);
    tick(pp_m, 1'b1, 1'b1, 1'b0, "R9", 1'b1);
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule